// File: doc/BRIEF.md
# USB Receive Endpoint Status Register

This block keeps the receive status of one USB OUT endpoint and presents it to firmware as one 8-bit word on a simple read-strobe bus. A receive engine reports each finished packet with a one-cycle event. The event carries the PID parity, the zero-length, setup and media-error qualifiers, the low bit of the frame number and the isochronous mode of the endpoint. The block folds each event into the status flags. The byte-count field is sampled from the live FIFO occupancy at read time.

Every flag clears when firmware reads it. A zero-length packet can be followed immediately by a SETUP packet that carries data. For that case a second status copy holds the SETUP status while the zero-length status waits to be read. Two back-to-back reads therefore return both packets' status in arrival order.

Top module: `usb_rx_status_reg`

## Requirements
- R1: A synchronous active-high reset clears every flag, empties the second copy and drives `rd_data` to 0.
- R2: `rd_data[3:0]` holds the `fifo_level` seen at the read strobe, limited to 15 when the level is larger.
- R3: In non-isochronous mode a good packet sets `rd_data[5]` (toggle) when the PID is DATA1 and clears it when the PID is DATA0. A good zero-length packet leaves the toggle as it was.
- R4: In isochronous mode a good packet copies `evt_frame_lsb` into the toggle bit 5, whatever its PID.
- R5: A read clears bits 7:4 (error, setup, toggle, last). A second read with no event in between returns only the count.
- R6: An event with `evt_err` set raises bit 7 and leaves bits 6:4 unchanged.
- R7: A good packet sets the last-data bit 4. A good SETUP packet also sets bit 6.
- R8: A good zero-length packet may be followed, before any read, by a good SETUP packet with data. The first read then returns the zero-length status and the second read returns the SETUP status. Later events update that second status until it is read.
- R9: An event in the same cycle as a read strobe is not lost. The read returns the status from before the event, and the event's bits remain for the next read.
- R10: `rd_data` is registered. It changes only on the clock edge that samples `rd_stb` and is valid from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_valid | input | 1 | One-cycle pulse: a packet has finished |
| evt_data1 | input | 1 | Packet PID was DATA1 (0 means DATA0) |
| evt_zlen | input | 1 | Packet carried no data bytes |
| evt_setup | input | 1 | Packet was a SETUP transaction |
| evt_err | input | 1 | Media error (bit stuffing, CRC) |
| evt_frame_lsb | input | 1 | Bit 0 of the current frame number |
| iso_mode | input | 1 | Endpoint is isochronous |
| fifo_level | input | LEVEL_W | Live receive FIFO byte count |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_data | output | 8 | Status word: err, setup, toggle, last, count[3:0] |

## Verification
A wrong internal state shows up on `rd_data` one cycle after the next read strobe, and nowhere else, because the output is a registered snapshot. A second copy that is loaded wrongly or promoted too early shows as a swapped or missing setup bit on the first or second of two consecutive reads. A clear that is lost or that comes too early shows as stale or missing upper bits on a follow-up read. Isolated events mixed with reads catch toggle and error-flag faults. Directed sequences catch collisions between events and reads and the ordering of the two copies.

// File: rtl/usb_rxs_pkg.sv
package usb_rxs_pkg;

  typedef struct packed {
    logic err;
    logic setup;
    logic toggle;
    logic last;
  } rxs_flags_t;

  localparam int unsigned FLAGS_W = 4;

endpackage

// File: rtl/usb_rxs_count_sat.sv
module usb_rxs_count_sat #(
  parameter int unsigned IN_W  = 7,
  parameter int unsigned OUT_W = 4
) (
  input  logic [IN_W-1:0]  level,
  output logic [OUT_W-1:0] count
);

  generate
    if (IN_W > OUT_W) begin : g_sat
      localparam logic [IN_W-1:0] LIM = IN_W'((1 << OUT_W) - 1);
      assign count = (level > LIM) ? {OUT_W{1'b1}} : level[OUT_W-1:0];
    end else begin : g_pass
      assign count = OUT_W'(level);
    end
  endgenerate

endmodule

// File: rtl/usb_rxs_apply.sv
module usb_rxs_apply
  import usb_rxs_pkg::*;
(
  input  rxs_flags_t base,
  input  logic       hit,
  input  logic       iso,
  input  logic       data1,
  input  logic       zlen,
  input  logic       setup,
  input  logic       err,
  input  logic       frame_lsb,
  output rxs_flags_t nxt
);

  always_comb begin
    nxt = base;
    if (hit) begin
      if (err) begin
        nxt.err = 1'b1;
      end else begin
        nxt.last  = 1'b1;
        nxt.setup = base.setup | setup;
        if (iso)
          nxt.toggle = frame_lsb;
        else if (!zlen)
          nxt.toggle = data1;
      end
    end
  end

endmodule

// File: rtl/usb_rx_status_reg.sv
module usb_rx_status_reg
  import usb_rxs_pkg::*;
#(
  parameter int unsigned LEVEL_W = 7,
  parameter int unsigned CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evt_valid,
  input  logic               evt_data1,
  input  logic               evt_zlen,
  input  logic               evt_setup,
  input  logic               evt_err,
  input  logic               evt_frame_lsb,
  input  logic               iso_mode,
  input  logic [LEVEL_W-1:0] fifo_level,
  input  logic               rd_stb,
  output logic [FLAGS_W+CNT_W-1:0] rd_data
);

  localparam int unsigned DATA_W  = FLAGS_W + CNT_W;
  localparam int          CNT_MAX = (1 << CNT_W) - 1;

  rxs_flags_t prim_r, q_r;
  logic       q_valid, zl_pend;

  rxs_flags_t base_p, base_q, nxt_p, nxt_q;
  logic       base_qv, base_zl, to_q, to_p;
  logic [CNT_W-1:0] cnt_sat;

  // Read first: the base state is either held, promoted or cleared
  always_comb begin
    if (rd_stb) begin
      base_p  = q_valid ? q_r : '0;
      base_q  = '0;
      base_qv = 1'b0;
      base_zl = 1'b0;
    end else begin
      base_p  = prim_r;
      base_q  = q_r;
      base_qv = q_valid;
      base_zl = zl_pend;
    end
    to_q = evt_valid &&
           (base_qv || (base_zl && evt_setup && !evt_zlen && !evt_err));
    to_p = evt_valid && !to_q;
  end

  usb_rxs_apply u_app_p (
    .base(base_p), .hit(to_p), .iso(iso_mode), .data1(evt_data1),
    .zlen(evt_zlen), .setup(evt_setup), .err(evt_err),
    .frame_lsb(evt_frame_lsb), .nxt(nxt_p)
  );

  usb_rxs_apply u_app_q (
    .base(base_q), .hit(to_q), .iso(iso_mode), .data1(evt_data1),
    .zlen(evt_zlen), .setup(evt_setup), .err(evt_err),
    .frame_lsb(evt_frame_lsb), .nxt(nxt_q)
  );

  usb_rxs_count_sat #(.IN_W(LEVEL_W), .OUT_W(CNT_W)) u_sat (
    .level(fifo_level), .count(cnt_sat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prim_r  <= '0;
      q_r     <= '0;
      q_valid <= 1'b0;
      zl_pend <= 1'b0;
      rd_data <= '0;
    end else begin
      prim_r  <= nxt_p;
      q_r     <= nxt_q;
      q_valid <= base_qv | to_q;
      zl_pend <= (to_p && !evt_err) ? evt_zlen : base_zl;
      if (rd_stb)
        rd_data <= {prim_r, cnt_sat};
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (rd_data == '0) && !q_valid);  // R1

  AST_COUNT_SAT: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> (int'(rd_data[CNT_W-1:0]) ==
      ((int'($past(fifo_level)) > CNT_MAX) ? CNT_MAX : int'($past(fifo_level)))));  // R2

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !evt_valid && !q_valid) |=> (prim_r == '0));  // R5

  AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_err && !q_valid) |=> prim_r.err);  // R6

  AST_QUEUE_SETUP: assert property (@(posedge clk) disable iff (rst)
    $rose(q_valid) |-> (q_r.setup && !q_r.err));  // R8

  AST_QUEUE_BEHIND_ZLEN: assert property (@(posedge clk) disable iff (rst)
    q_valid |-> zl_pend);  // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));  // R10

  initial begin
    AST_WIDTH: assert (DATA_W == 8);  // R2
  end

endmodule

// File: tb/usb_rx_status_reg_tb.sv
module usb_rx_status_reg_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evt_valid = 0, evt_data1 = 0, evt_zlen = 0, evt_setup = 0;
  logic       evt_err = 0, evt_frame_lsb = 0, iso_mode = 0;
  logic [6:0] fifo_level = '0;
  logic       rd_stb = 0;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;  // 250 MHz

  usb_rx_status_reg u_dut (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_data1(evt_data1),
    .evt_zlen(evt_zlen), .evt_setup(evt_setup), .evt_err(evt_err),
    .evt_frame_lsb(evt_frame_lsb), .iso_mode(iso_mode),
    .fifo_level(fifo_level), .rd_stb(rd_stb), .rd_data(rd_data)
  );

  typedef struct packed {
    logic       ev, iso, d1, zl, su, er, fr;
    logic [6:0] lvl;
    logic [7:0] exp;
    logic [3:0] tag;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1,0,1,0,0,0,0, 7'd5,   8'h35, 4'd3},  // R3 DATA1 sets toggle
    '{1,0,0,0,0,0,0, 7'd20,  8'h1F, 4'd2},  // R2 count saturates
    '{1,1,0,0,0,0,1, 7'd15,  8'h3F, 4'd4},  // R4 ISO frame bit 1
    '{1,1,1,0,0,0,0, 7'd0,   8'h10, 4'd4},  // R4 ISO frame bit 0
    '{1,0,0,0,0,1,0, 7'd3,   8'h83, 4'd6},  // R6 error only
    '{1,0,0,0,1,0,0, 7'd8,   8'h58, 4'd7},  // R7 setup + last
    '{0,0,0,0,0,0,0, 7'd100, 8'h0F, 4'd5},  // R5 cleared by previous read
    '{1,0,1,1,0,0,0, 7'd16,  8'h1F, 4'd3}   // R3 zero length keeps toggle
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails + 0);
      $finish;
    end
  end

  task automatic chk(input int tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_evt(input logic iso, d1, zl, su, er, fr, input logic with_rd);
    @(negedge clk);
    iso_mode = iso; evt_data1 = d1; evt_zlen = zl; evt_setup = su;
    evt_err = er; evt_frame_lsb = fr; evt_valid = 1'b1; rd_stb = with_rd;
    @(negedge clk);
    evt_valid = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic do_read(input int tag, input logic [7:0] exp);
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(1, rd_data, 8'h00);            // R1 output after reset
    do_read(1, 8'h00);                 // R1 flags and count zero

    for (int i = 0; i < 8; i++) begin
      fifo_level = VEC[i].lvl;
      if (VEC[i].ev)
        drive_evt(VEC[i].iso, VEC[i].d1, VEC[i].zl, VEC[i].su,
                  VEC[i].er, VEC[i].fr, 1'b0);
      do_read(int'(VEC[i].tag), VEC[i].exp);
    end

    // R3: zero-length after DATA1 keeps toggle high
    fifo_level = 7'd0;
    drive_evt(0, 1, 0, 0, 0, 0, 0);
    drive_evt(0, 0, 1, 0, 0, 0, 0);
    do_read(3, 8'h30);

    // R6: error leaves toggle and last untouched
    drive_evt(0, 1, 0, 0, 0, 0, 0);
    drive_evt(0, 0, 0, 0, 1, 0, 0);
    do_read(6, 8'hB0);

    // R8: zero-length, then SETUP with data, two ordered reads
    fifo_level = 7'd8;
    drive_evt(0, 0, 1, 0, 0, 0, 0);
    drive_evt(1, 0, 0, 1, 0, 1, 0);
    do_read(8, 8'h18);
    do_read(8, 8'h78);
    do_read(5, 8'h08);                 // R5 both copies now clear

    // R9: event collides with read; event survives
    fifo_level = 7'd2;
    drive_evt(0, 1, 0, 0, 0, 0, 1);
    chk(9, rd_data, 8'h02);
    do_read(9, 8'h32);

    // R10: output holds without a strobe
    fifo_level = 7'd9;
    drive_evt(0, 0, 0, 1, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(10, rd_data, 8'h32);

    // R1: reset mid-run clears pending status
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    fifo_level = 7'd0;
    chk(1, rd_data, 8'h00);
    do_read(1, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule